// File: doc/BRIEF.md
# Dual-Edge Input Data Formatter

This block takes a 16-bit parallel sample bus that arrives together with a forwarded data clock. It turns the bus into a stream of converter codes, each marked by a one-cycle valid strobe. The forwarded data clock is not used as a clock. The block samples it as a level in the local clock domain, so the local clock must run well above the data clock. A word is taken when the sampled level changes in the chosen direction.

In single-rate mode one edge direction captures a word. In double-rate mode both edges capture a word, so the data clock runs at half the word rate and the words leave in the order they arrived. Each word is converted to an offset-binary code: twos-complement input has its top bit flipped, and unsigned input passes through unchanged. The result is that all zeros means zero current and all ones means full scale.

A regenerated clock output follows the sampled data clock. It is aligned with the output word and can be inverted or switched off. All mode inputs are static control lines, and their reset meaning is 0.

Top module: `dual_edge_formatter`

## Requirements
- R1: While rst_n is low, dout is 0, dout_valid is 0, dco is 0 and dco_en is 0.
- R2: With cfg_ddr=0 and cfg_fall_in=0, a word is taken only when dclk_in goes 0 to 1. dout_valid then pulses for one cycle on the second rising clk edge after the first clk edge that samples the new dclk_in level. A 1 to 0 change captures nothing.
- R3: With cfg_ddr=0 and cfg_fall_in=1, a word is taken only when dclk_in goes 1 to 0. A 0 to 1 change captures nothing.
- R4: With cfg_ddr=1, every change of dclk_in captures one word, whatever cfg_fall_in holds. Words appear on dout in arrival order.
- R5: With cfg_unsigned=0 the input is twos complement, and dout equals the input with bit 15 inverted (0x8000 gives 0x0000, 0x7FFF gives 0xFFFF).
- R6: With cfg_unsigned=1, dout equals the captured input word unchanged.
- R7: dout keeps its value in every cycle where dout_valid is 0.
- R8: With cfg_dco_off=0, dco equals the sampled dclk_in level XOR cfg_fall_out, and it changes in the same cycle as the matching output word.
- R9: With cfg_dco_off=1, dco is 0 and dco_en is 0 from the next clk edge onward; capture continues. With cfg_dco_off=0 out of reset, dco_en is 1.
- R10: While dclk_in holds its level, no word is captured even if din changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ddr | input | 1 | 0 single-rate, 1 double-rate capture |
| cfg_fall_in | input | 1 | Single-rate capture edge: 0 rising, 1 falling |
| cfg_fall_out | input | 1 | Output clock polarity: 0 true, 1 inverted |
| cfg_dco_off | input | 1 | 1 turns the output clock off |
| cfg_unsigned | input | 1 | 0 twos complement, 1 unsigned input |
| dclk_in | input | 1 | Forwarded data clock, sampled as a level |
| din | input | 16 | Parallel sample bus |
| dout | output | 16 | Offset-binary output code |
| dout_valid | output | 1 | One-cycle strobe marking a new dout |
| dco | output | 1 | Regenerated output clock |
| dco_en | output | 1 | Output clock enable |

## Verification
Two things happen in the same clock cycle: a new word appears on dout, and the regenerated clock changes level. A single data-clock edge causes both, so they are provoked together every time the bench moves dclk_in.

The bench samples dout, dout_valid and dco once, at the falling clk edge two cycles after the toggle. It judges the code and the clock level in that one sample against values it computed itself from the edge direction, the polarity bit and the format bit. An embedded property also requires that every valid strobe coincides with a change of the aligned clock level.

// File: rtl/dfmt_pkg.sv
package dfmt_pkg;
    localparam int DFMT_W = 16;

    typedef struct packed {
        logic ddr;
        logic fall_in;
        logic fall_out;
        logic dco_off;
        logic is_unsigned;
    } dfmt_cfg_t;
endpackage

// File: rtl/dfmt_edge_capture.sv
module dfmt_edge_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_ddr,
    input  logic         cfg_fall_in,
    input  logic         dclk_in,
    input  logic [W-1:0] din,
    output logic         cap_vld,
    output logic [W-1:0] cap_word,
    output logic         lvl
);
    typedef struct packed {
        logic         s1;
        logic         s2;
        logic [W-1:0] word;
    } st_t;

    st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = dclk_in;
        st_d.s2   = st_q.s1;
        st_d.word = din;
        rise      = st_q.s1 & ~st_q.s2;
        fall      = ~st_q.s1 & st_q.s2;
        if (cfg_ddr) cap_vld = rise | fall;
        else         cap_vld = cfg_fall_in ? fall : rise;
        cap_word  = st_q.word;
        lvl       = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: single-rate falling mode never captures on a rising level change
    assert_no_rise_in_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ddr && cfg_fall_in && cap_vld) |-> !lvl);
endmodule

// File: rtl/dfmt_format.sv
module dfmt_format #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         is_unsigned,
    input  logic         vld_in,
    input  logic [W-1:0] word_in,
    output logic         vld_out,
    output logic [W-1:0] word_out
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_in;
        if (vld_in) begin
            st_d.word = word_in;
            if (!is_unsigned) st_d.word[MSB] = ~word_in[MSB];
        end
        vld_out  = st_q.vld;
        word_out = st_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_unsigned_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && is_unsigned) |=> (word_out == $past(word_in)));

    assert_twos_msb_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && !is_unsigned) |=> (word_out[MSB] != $past(word_in[MSB])));
endmodule

// File: rtl/dfmt_clkout.sv
module dfmt_clkout (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic fall_out,
    input  logic off,
    output logic dco,
    output logic dco_en,
    output logic lvl_out
);
    typedef struct packed {
        logic lvl;
        logic dco;
        logic en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_in;
        st_d.dco = off ? 1'b0 : (lvl_in ^ fall_out);
        st_d.en  = ~off;
        dco      = st_q.dco;
        dco_en   = st_q.en;
        lvl_out  = st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_dco_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> (!dco && !dco_en));
endmodule

// File: rtl/dual_edge_formatter.sv
module dual_edge_formatter
    import dfmt_pkg::*;
#(
    parameter int W = DFMT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_ddr,
    input  logic         cfg_fall_in,
    input  logic         cfg_fall_out,
    input  logic         cfg_dco_off,
    input  logic         cfg_unsigned,
    input  logic         dclk_in,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_valid,
    output logic         dco,
    output logic         dco_en
);
    dfmt_cfg_t    cfg;
    logic         cap_vld;
    logic [W-1:0] cap_word;
    logic         lvl;
    logic         lvl_aligned;

    always_comb begin
        cfg.ddr         = cfg_ddr;
        cfg.fall_in     = cfg_fall_in;
        cfg.fall_out    = cfg_fall_out;
        cfg.dco_off     = cfg_dco_off;
        cfg.is_unsigned = cfg_unsigned;
    end

    dfmt_edge_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cfg_ddr(cfg.ddr), .cfg_fall_in(cfg.fall_in),
        .dclk_in(dclk_in), .din(din), .cap_vld(cap_vld), .cap_word(cap_word), .lvl(lvl)
    );

    dfmt_format #(.W(W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .is_unsigned(cfg.is_unsigned), .vld_in(cap_vld),
        .word_in(cap_word), .vld_out(dout_valid), .word_out(dout)
    );

    dfmt_clkout u_dco (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl), .fall_out(cfg.fall_out),
        .off(cfg.dco_off), .dco(dco), .dco_en(dco_en), .lvl_out(lvl_aligned)
    );

    assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> $stable(dout));

    assert_valid_on_clock_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (lvl_aligned != $past(lvl_aligned)));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!dout_valid && !dco_en));
endmodule

// File: tb/dual_edge_formatter_tb.sv
module dual_edge_formatter_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_ddr = 0, cfg_fall_in = 0, cfg_fall_out = 0, cfg_dco_off = 0, cfg_unsigned = 0;
    logic        dclk_in = 0;
    logic [15:0] din = 0;
    logic [15:0] dout;
    logic        dout_valid, dco, dco_en;
    int          errors = 0;
    int          checks = 0;
    logic [15:0] last_out = 0;

    always #2.5 clk = ~clk;

    dual_edge_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ddr(cfg_ddr), .cfg_fall_in(cfg_fall_in),
        .cfg_fall_out(cfg_fall_out), .cfg_dco_off(cfg_dco_off), .cfg_unsigned(cfg_unsigned),
        .dclk_in(dclk_in), .din(din), .dout(dout), .dout_valid(dout_valid),
        .dco(dco), .dco_en(dco_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] conv(input logic [15:0] w);
        return cfg_unsigned ? w : {~w[15], w[14:0]};
    endfunction

    // drive word, toggle data clock, look two cycles later
    task automatic edge_step(input logic [15:0] w, input bit expect_cap, input string req);
        logic [15:0] exp_w;
        logic        exp_dco;
        @(negedge clk) din = w;
        @(negedge clk) dclk_in = ~dclk_in;
        @(negedge clk);
        @(negedge clk);
        exp_w = expect_cap ? conv(w) : last_out;
        check(dout_valid == expect_cap, req, dout_valid, expect_cap);
        check(dout == exp_w, req, dout, exp_w);
        exp_dco = cfg_dco_off ? 1'b0 : (dclk_in ^ cfg_fall_out);
        check(dco == exp_dco, cfg_dco_off ? "R9 dco" : "R8 dco", dco, exp_dco);
        last_out = exp_w;
        @(negedge clk);
        check(dout_valid == 0, "R7 pulse", dout_valid, 0);
        check(dout == exp_w, "R7 hold", dout, exp_w);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(dout == 0 && dout_valid == 0, "R1 out", dout, 0);
        check(dco == 0 && dco_en == 0, "R1 clk", {dco, dco_en}, 0);
        rst_n = 1;
        @(negedge clk);
        check(dco_en == 1, "R9 enable", dco_en, 1);
    endtask

    task automatic t_sdr_rise;
        cfg_ddr = 0; cfg_fall_in = 0; cfg_unsigned = 0;
        edge_step(16'h1234, 1, "R2 rise");
        edge_step(16'h5555, 0, "R2 fall ignored");
        edge_step(16'h7FFF, 1, "R5 7FFF");
        edge_step(16'h0000, 0, "R2 fall ignored");
    endtask

    task automatic t_steady;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) din = 16'hC3C3 ^ 16'(i);
            check(dout_valid == 0, "R10 steady", dout_valid, 0);
        end
        check(dout == last_out, "R10 dout", dout, last_out);
    endtask

    task automatic t_sdr_fall;
        cfg_fall_in = 1;
        edge_step(16'hAAAA, 0, "R3 rise ignored");
        edge_step(16'h0001, 1, "R3 fall");
    endtask

    task automatic t_ddr;
        cfg_ddr = 1; cfg_fall_in = 1; cfg_unsigned = 1;
        edge_step(16'h0000, 1, "R4 R6 w0");
        edge_step(16'hFFFF, 1, "R4 R6 w1");
        edge_step(16'h1357, 1, "R4 R6 w2");
        edge_step(16'h8000, 1, "R4 R6 w3");
        cfg_unsigned = 0;
        edge_step(16'h8000, 1, "R5 8000");
        edge_step(16'h7FFF, 1, "R5 7FFF");
    endtask

    task automatic t_dco_pol;
        cfg_fall_out = 1;
        edge_step(16'h2468, 1, "R8 inverted");
        edge_step(16'h0F0F, 1, "R8 inverted");
        cfg_fall_out = 0;
    endtask

    task automatic t_dco_off;
        @(negedge clk) cfg_dco_off = 1;
        @(negedge clk);
        check(dco == 0 && dco_en == 0, "R9 off", {dco, dco_en}, 0);
        edge_step(16'h4321, 1, "R9 capture continues");
        edge_step(16'h1111, 1, "R9 capture continues");
        @(negedge clk) cfg_dco_off = 0;
        @(negedge clk);
        check(dco_en == 1, "R9 re-enable", dco_en, 1);
    endtask

    initial begin
        t_reset();
        t_sdr_rise();
        t_steady();
        t_sdr_fall();
        t_ddr();
        t_dco_pol();
        t_dco_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule